// File: doc/BRIEF.md
# Phase/Frequency Detector Controller with Test Override

This block sits between the reference divider and the VCO programmable divider of a frequency synthesizer. It watches the rising edges of the reference pulse stream and of the divided-VCO pulse stream. It drives the two enables of an external charge pump: source, sink, or neither (high impedance). Each comparison is closed by the edge that arrives second. While one edge is still waiting for its partner, further edges on the same input are ignored. This makes the detector sensitive to frequency as well as to phase.

A small lock monitor measures how far apart the two edges of each comparison are. After four comparisons in a row that fall within a two-cycle window, it raises a lock flag. A single comparison outside the window drops the flag. A registered 3-bit test field can override the pump enables and choose what a shared ADC/test pin carries. A registered current-select bit picks the pump current.

The core detector has three states: `PFD_IDLE`, `PFD_SRC` and `PFD_SNK`. It moves IDLE→SRC on a lone divided edge, IDLE→SNK on a lone reference edge, SRC→IDLE on a reference edge, and SNK→IDLE on a divided edge. When both edges arrive together in IDLE, it stays in IDLE. The lock monitor has two states, `LK_SEARCH` and `LK_LOCKED`. It moves SEARCH→LOCKED on the fourth consecutive in-window comparison and LOCKED→SEARCH on any out-of-window comparison. The decoded test modes are `TM_NORMAL`, `TM_HIZ`, `TM_SINK`, `TM_SOURCE`, `TM_REFOUT` and `TM_DIVOUT`.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: A rising edge on `div_pulse` alone while idle raises `pump_src` at the clock edge that samples it. `pump_src` stays high until the clock edge that samples a rising edge on `ref_pulse`, and then falls.
- R2: A rising edge on `ref_pulse` alone while idle raises `pump_snk` at the clock edge that samples it. `pump_snk` stays high until a `div_pulse` rising edge is sampled.
- R3: Rising edges on both inputs sampled at the same clock edge leave both enables low (high impedance).
- R4: While sourcing, further `div_pulse` edges are ignored: `pump_src` stays high and `pump_snk` stays low until a reference edge. The same holds for sinking with reference edges.
- R5: `pump_src` and `pump_snk` are never high together.
- R6: The test field is registered; its value takes effect one clock after it is applied. With the field at 000 or 001, the enables follow the detector. With 010 or 011, both enables are held low, and the detector state is kept for when normal mode returns.
- R7: Test field 110 forces `pump_snk` high and `pump_src` low. Test field 111 forces `pump_src` high and `pump_snk` low.
- R8: Test field 100 holds both enables low and sets `tpin_sel` to 1 (reference pulse routed out). Test field 101 holds both enables low and sets `tpin_sel` to 2 (divided pulse routed out). In every other mode, `tpin_sel` is 0 (ADC input).
- R9: `cp_hi` shows the value of `cp_high_sel` registered one clock earlier. A value of 1 selects the high pump current and 0 selects the low current.
- R10: `lock_flag` rises at the clock edge that samples the closing edge of the fourth consecutive comparison whose two edges are at most 2 clock cycles apart.
- R11: `lock_flag` falls at the clock edge that samples the closing edge of the first comparison whose edges are more than 2 cycles apart. The in-window count then restarts from zero.
- R12: During and right after reset, `pump_src`=0, `pump_snk`=0, `cp_hi`=1, `lock_flag`=0 and `tpin_sel`=0, and the test mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | Reference pulse stream, synchronous to clk |
| div_pulse | input | 1 | Divided-VCO pulse stream, synchronous to clk |
| test_mode | input | 3 | Test field {T2,T1,T0} |
| cp_high_sel | input | 1 | Pump current select, 1 = high |
| pump_src | output | 1 | Charge pump source enable |
| pump_snk | output | 1 | Charge pump sink enable |
| cp_hi | output | 1 | Registered pump current select |
| lock_flag | output | 1 | 1 when the loop is judged locked |
| tpin_sel | output | 2 | Shared pin select: 0 ADC, 1 reference, 2 divided |

## Verification
On every cycle, the assertions check the following: the two pump enables are mutually exclusive; the forced source and reference-out modes take effect one clock after the field is applied; the current select tracks its input with one register of delay; coincident edges in normal mode produce no pump activity; and an out-of-window comparison always clears lock. Only the directed scenarios can show the rest. These are the exact cycle at which sourcing and sinking begin and end, that repeated edges on one input are ignored, that the detector state survives a high-impedance override, and the count of four in-window comparisons that lets the lock flag rise.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_SRC  = 2'd1,
        PFD_SNK  = 2'd2
    } pfd_state_e;

    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_e;

    typedef enum logic [2:0] {
        TM_NORMAL = 3'd0,
        TM_HIZ    = 3'd1,
        TM_SINK   = 3'd2,
        TM_SOURCE = 3'd3,
        TM_REFOUT = 3'd4,
        TM_DIVOUT = 3'd5
    } test_mode_e;

    localparam logic [1:0] TP_ADC = 2'd0;
    localparam logic [1:0] TP_REF = 2'd1;
    localparam logic [1:0] TP_DIV = 2'd2;

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] pulse_in,
    output logic [CH-1:0] rise
);
    logic [CH-1:0] prev_q;

    for (genvar i = 0; i < CH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= pulse_in[i];
        end
        assign rise[i] = pulse_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             div_rise,
    output logic             det_src,
    output logic             det_snk,
    output logic             cmp_evt,
    output logic [GAP_W-1:0] cmp_gap
);
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    pfd_state_e       state_q, state_d;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PFD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cmp_evt = 1'b0;
        unique case (state_q)
            PFD_IDLE: begin
                if (div_rise && ref_rise) cmp_evt = 1'b1;
                else if (div_rise)        state_d = PFD_SRC;
                else if (ref_rise)        state_d = PFD_SNK;
            end
            PFD_SRC: begin
                if (ref_rise) begin
                    state_d = PFD_IDLE;
                    cmp_evt = 1'b1;
                end
            end
            PFD_SNK: begin
                if (div_rise) begin
                    state_d = PFD_IDLE;
                    cmp_evt = 1'b1;
                end
            end
            default: state_d = PFD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       gap_q <= '0;
        else if (state_d == PFD_IDLE)     gap_q <= '0;
        else if (state_q == PFD_IDLE)     gap_q <= GAP_W'(1);
        else if (gap_q != GAP_MAX)        gap_q <= gap_q + GAP_W'(1);
    end

    always_comb begin
        det_src = (state_q == PFD_SRC);
        det_snk = (state_q == PFD_SNK);
        cmp_gap = (state_q == PFD_IDLE) ? '0 : gap_q;
    end
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
    import pfd_pkg::*;
#(
    parameter int GAP_W    = 4,
    parameter int WIN      = 2,
    parameter int LOCK_CNT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_evt,
    input  logic [GAP_W-1:0] cmp_gap,
    output logic             locked
);
    localparam int CNT_W = $clog2(LOCK_CNT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CNT - 1);

    lock_state_e      state_q, state_d;
    logic [CNT_W-1:0] good_q, good_d;
    logic             in_win;

    assign in_win = (int'(cmp_gap) <= WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_SEARCH;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        unique case (state_q)
            LK_SEARCH: begin
                if (cmp_evt && in_win) begin
                    if (good_q == LAST) state_d = LK_LOCKED;
                    else                good_d  = good_q + CNT_W'(1);
                end else if (cmp_evt) begin
                    good_d = '0;
                end
            end
            LK_LOCKED: begin
                if (cmp_evt && !in_win) begin
                    state_d = LK_SEARCH;
                    good_d  = '0;
                end
            end
            default: begin
                state_d = LK_SEARCH;
                good_d  = '0;
            end
        endcase
    end

    always_comb locked = (state_q == LK_LOCKED);
endmodule

// File: rtl/pfd_mode.sv
module pfd_mode
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] test_mode,
    input  logic       cp_high_sel,
    output test_mode_e mode,
    output logic       cp_hi
);
    logic [2:0] tm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q  <= 3'b000;
            cp_hi <= 1'b1;
        end else begin
            tm_q  <= test_mode;
            cp_hi <= cp_high_sel;
        end
    end

    always_comb begin
        unique casez (tm_q)
            3'b00?:  mode = TM_NORMAL;
            3'b01?:  mode = TM_HIZ;
            3'b110:  mode = TM_SINK;
            3'b111:  mode = TM_SOURCE;
            3'b100:  mode = TM_REFOUT;
            3'b101:  mode = TM_DIVOUT;
            default: mode = TM_NORMAL;
        endcase
    end
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl
    import pfd_pkg::*;
#(
    parameter int GAP_W    = 4,
    parameter int WIN      = 2,
    parameter int LOCK_CNT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_pulse,
    input  logic       div_pulse,
    input  logic [2:0] test_mode,
    input  logic       cp_high_sel,
    output logic       pump_src,
    output logic       pump_snk,
    output logic       cp_hi,
    output logic       lock_flag,
    output logic [1:0] tpin_sel
);
    logic [1:0]       rise;
    logic             ref_rise, div_rise;
    logic             det_src, det_snk;
    logic             cmp_evt;
    logic [GAP_W-1:0] cmp_gap;
    test_mode_e       mode;

    pfd_edge #(.CH(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in ({div_pulse, ref_pulse}),
        .rise     (rise)
    );
    assign ref_rise = rise[0];
    assign div_rise = rise[1];

    pfd_core #(.GAP_W(GAP_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (ref_rise),
        .div_rise (div_rise),
        .det_src  (det_src),
        .det_snk  (det_snk),
        .cmp_evt  (cmp_evt),
        .cmp_gap  (cmp_gap)
    );

    pfd_lock #(.GAP_W(GAP_W), .WIN(WIN), .LOCK_CNT(LOCK_CNT)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_evt (cmp_evt),
        .cmp_gap (cmp_gap),
        .locked  (lock_flag)
    );

    pfd_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_mode   (test_mode),
        .cp_high_sel (cp_high_sel),
        .mode        (mode),
        .cp_hi       (cp_hi)
    );

    always_comb begin
        pump_src = 1'b0;
        pump_snk = 1'b0;
        tpin_sel = TP_ADC;
        unique case (mode)
            TM_NORMAL: begin
                pump_src = det_src;
                pump_snk = det_snk;
            end
            TM_HIZ:    ;
            TM_SINK:   pump_snk = 1'b1;
            TM_SOURCE: pump_src = 1'b1;
            TM_REFOUT: tpin_sel = TP_REF;
            TM_DIVOUT: tpin_sel = TP_DIV;
            default:   ;
        endcase
    end
endmodule

// File: rtl/pfd_cp_ctrl_chk.sv
module pfd_cp_ctrl_chk
    import pfd_pkg::*;
#(
    parameter int GAP_W = 4,
    parameter int WIN   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       test_mode,
    input logic             cp_high_sel,
    input logic             pump_src,
    input logic             pump_snk,
    input logic             cp_hi,
    input logic             lock_flag,
    input logic [1:0]       tpin_sel,
    input logic             ref_rise,
    input logic             div_rise,
    input logic             cmp_evt,
    input logic [GAP_W-1:0] cmp_gap,
    input test_mode_e       mode
);
    // R5
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_src && pump_snk));

    // R7
    force_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_mode) == 3'b111) |-> (pump_src && !pump_snk));

    // R8
    refout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_mode) == 3'b100) |-> (tpin_sel == TP_REF && !pump_src && !pump_snk));

    // R9
    cp_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cp_hi == $past(cp_high_sel)));

    // R3
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_NORMAL && !pump_src && !pump_snk && ref_rise && div_rise)
        |=> (mode != TM_NORMAL || (!pump_src && !pump_snk)));

    // R11
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && cmp_evt && int'(cmp_gap) > WIN) |=> !lock_flag);

    // R10
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> ($past(cmp_evt) && int'($past(cmp_gap)) <= WIN));
endmodule

bind pfd_cp_ctrl pfd_cp_ctrl_chk #(.GAP_W(GAP_W), .WIN(WIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode   (test_mode),
    .cp_high_sel (cp_high_sel),
    .pump_src    (pump_src),
    .pump_snk    (pump_snk),
    .cp_hi       (cp_hi),
    .lock_flag   (lock_flag),
    .tpin_sel    (tpin_sel),
    .ref_rise    (ref_rise),
    .div_rise    (div_rise),
    .cmp_evt     (cmp_evt),
    .cmp_gap     (cmp_gap),
    .mode        (mode)
);

// File: tb/pfd_cp_ctrl_test.sv
module pfd_cp_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b0;
    logic       div_pulse = 1'b0;
    logic [2:0] test_mode = 3'b000;
    logic       cp_high_sel = 1'b0;
    logic       pump_src, pump_snk, cp_hi, lock_flag;
    logic [1:0] tpin_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pfd_cp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
        .test_mode(test_mode), .cp_high_sel(cp_high_sel),
        .pump_src(pump_src), .pump_snk(pump_snk), .cp_hi(cp_hi),
        .lock_flag(lock_flag), .tpin_sel(tpin_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pump(input string req, input int src, input int snk);
        chk({req, " src"}, int'(pump_src), src);
        chk({req, " snk"}, int'(pump_snk), snk);
    endtask

    // one idle cycle, then edges on the chosen inputs; returns after they are sampled
    task automatic edges(input logic r, input logic d);
        @(negedge clk);
        ref_pulse = r;
        div_pulse = d;
        @(negedge clk);
        ref_pulse = 1'b0;
        div_pulse = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        test_mode = m;
        @(negedge clk);
    endtask

    task automatic t_reset();
        test_mode = 3'b111;
        cp_high_sel = 1'b0;
        idle(3);
        pump("R12 in reset", 0, 0);
        chk("R12 cp_hi", int'(cp_hi), 1);
        chk("R12 lock", int'(lock_flag), 0);
        chk("R12 tpin", int'(tpin_sel), 0);
        test_mode = 3'b000;
        cp_high_sel = 1'b1;
        rst_n = 1'b1;
        idle(1);
        pump("R12 after reset", 0, 0);
    endtask

    task automatic t_source();
        edges(0, 1);
        pump("R1 div first", 1, 0);
        idle(2);
        pump("R1 held", 1, 0);
        edges(1, 0);
        pump("R1 closed by ref", 0, 0);
    endtask

    task automatic t_sink();
        edges(1, 0);
        pump("R2 ref first", 0, 1);
        edges(0, 1);
        pump("R2 closed by div", 0, 0);
    endtask

    task automatic t_coincide();
        edges(1, 1);
        pump("R3 together", 0, 0);
        idle(1);
        pump("R3 stays hiZ", 0, 0);
    endtask

    task automatic t_freq();
        edges(0, 1);
        edges(0, 1);
        pump("R4 extra div ignored", 1, 0);
        edges(1, 0);
        pump("R4 one ref closes", 0, 0);
        edges(1, 0);
        edges(1, 0);
        pump("R4 extra ref ignored", 0, 1);
        edges(0, 1);
        pump("R4 sink closes", 0, 0);
    endtask

    task automatic t_modes();
        set_mode(3'b001);
        edges(0, 1);
        pump("R6 mode 001 normal", 1, 0);
        set_mode(3'b011);
        pump("R6 mode 011 hiZ", 0, 0);
        set_mode(3'b010);
        pump("R6 mode 010 hiZ", 0, 0);
        set_mode(3'b000);
        pump("R6 state kept", 1, 0);
        edges(1, 0);
        set_mode(3'b110);
        pump("R7 forced sink", 0, 1);
        chk("R8 tpin in 110", int'(tpin_sel), 0);
        set_mode(3'b111);
        pump("R7 forced source", 1, 0);
        set_mode(3'b100);
        pump("R8 refout hiZ", 0, 0);
        chk("R8 tpin ref", int'(tpin_sel), 1);
        set_mode(3'b101);
        pump("R8 divout hiZ", 0, 0);
        chk("R8 tpin div", int'(tpin_sel), 2);
        set_mode(3'b000);
        chk("R8 tpin normal", int'(tpin_sel), 0);
    endtask

    task automatic t_cp();
        cp_high_sel = 1'b0;
        idle(1);
        chk("R9 low current", int'(cp_hi), 0);
        cp_high_sel = 1'b1;
        idle(1);
        chk("R9 high current", int'(cp_hi), 1);
    endtask

    task automatic t_lock();
        edges(0, 1);
        idle(3);
        edges(1, 0);
        chk("R10 start unlocked", int'(lock_flag), 0);
        edges(1, 1);
        chk("R10 after 1", int'(lock_flag), 0);
        edges(0, 1);
        edges(1, 0);
        chk("R10 after 2 (gap 2)", int'(lock_flag), 0);
        edges(1, 1);
        chk("R10 after 3", int'(lock_flag), 0);
        edges(1, 1);
        chk("R10 locked after 4", int'(lock_flag), 1);
        edges(0, 1);
        idle(3);
        chk("R11 still locked while waiting", int'(lock_flag), 1);
        edges(1, 0);
        chk("R11 dropped on wide gap", int'(lock_flag), 0);
        edges(1, 1);
        edges(1, 1);
        edges(1, 1);
        chk("R11 count restarted", int'(lock_flag), 0);
        edges(1, 1);
        chk("R10 relock", int'(lock_flag), 1);
    endtask

    initial begin
        t_reset();
        t_source();
        t_sink();
        t_coincide();
        t_freq();
        t_modes();
        t_cp();
        t_lock();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule